// File: doc/BRIEF.md
# Byte-Programmed Pulse Generator with Auto-Off Countdown

This block produces one pulse-width-modulated output from a period and a pulse width. Both are 16-bit counts of the block clock, so with an 8 MHz clock one count is 125 ns. Software sets the block up through a write-only byte port made of an address, a write strobe and a data byte. Each 16-bit quantity (period, pulse width and countdown preload) takes two byte writes. The upper byte is held in a staging register. The whole value goes live in one step when its lower byte is written, so the waveform never sees a half-written value.

A small controller decides whether the output runs. It has three states. In IDLE the output is low. In FREE the output runs with no time limit. In TIMED the output runs and a countdown is active. Four transitions move between them:

- start: a control write with bit 0 set leaves IDLE.
- stop: a control write with bit 0 clear returns to IDLE.
- rearm: any in-range write while running re-picks FREE or TIMED from the countdown preload.
- expire: the countdown runs out and TIMED returns to IDLE.

In TIMED the countdown drops by one on each millisecond tick. A preload of all ones selects FREE.

Top module: `bytereg_pwm`

## Requirements
- R1: Asynchronous active-low reset clears every register, the staging bytes, the preload and the controller state to zero or IDLE, and the output is low.
- R2: While running with a nonzero period P and a pulse width D < P, the output is high on cycles where the internal count is below D. The count runs 0..P-1, so the output is high for D of every P cycles.
- R3: Writes to the period upper byte (0xA5) or pulse-width upper byte (0xA7) change nothing visible. A write to the period lower byte (0xA4) or pulse-width lower byte (0xA6) makes {staged upper, written byte} live from the next cycle.
- R4: With a nonzero period and a pulse width ≥ period, the output stays high for whole cycles. This holds from the cycle after the period last changed.
- R5: Writing 0xA3 with bit 0 = 1 starts the output and restarts the count at 0, so the first cycle after the write is high when D > 0. Writing it with bit 0 = 0 stops the output. The output is low while stopped.
- R6: A period of 0 keeps the output low even while running.
- R7: The countdown preload is written upper byte at 0xA1 (staged) and lower byte at 0xA2 (commit). A preload of 0xFFFF selects FREE, and the output then never switches off by itself.
- R8: In TIMED, a millisecond tick occurs every TICKS_PER_MS cycles after the last in-range write. With a preload N ≥ 1 the controller returns to IDLE at the N-th tick; with N = 0 it returns at the first tick.
- R9: Every write to 0xA1..0xA7 reloads the countdown from the preload and restarts the tick prescaler.
- R10: Writes to addresses outside 0xA1..0xA7 change no register, no countdown and no output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Block clock; one count of period and pulse width |
| rst_n | input | 1 | Asynchronous reset, active low |
| wr_en | input | 1 | Byte write strobe |
| wr_addr | input | 8 | Register address of the write |
| wr_data | input | 8 | Byte written |
| pwm_o | output | 1 | Pulse output, normal polarity |

## Verification
If the controller is left in the wrong state, the damage shows within one cycle. The output either stays low through a cycle the model expects high or keeps switching after an expected expiry. An off-by-one in the wave counter or in the commit of a staged byte shifts the edge of the high window, and this shows within one period. A prescaler or countdown error moves the moment the output dies by at least one cycle. Comparing the output on every single cycle against a model exposes all of these at the first differing cycle.

// File: rtl/bpwm_pkg.sv
package bpwm_pkg;
    localparam int BYTE_W = 8;
    localparam int CNT_W  = 2 * BYTE_W;

    // Byte addresses; the upper/lower pairing is what the commit logic decodes
    localparam logic [BYTE_W-1:0] A_TMR_HI  = 8'hA1;
    localparam logic [BYTE_W-1:0] A_TMR_LO  = 8'hA2;
    localparam logic [BYTE_W-1:0] A_CTRL    = 8'hA3;
    localparam logic [BYTE_W-1:0] A_PER_LO  = 8'hA4;
    localparam logic [BYTE_W-1:0] A_PER_HI  = 8'hA5;
    localparam logic [BYTE_W-1:0] A_DUTY_LO = 8'hA6;
    localparam logic [BYTE_W-1:0] A_DUTY_HI = 8'hA7;

    localparam logic [CNT_W-1:0] TMR_NEVER = '1;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_FREE  = 2'd1,
        ST_TIMED = 2'd2
    } run_st_e;
endpackage

// File: rtl/bpwm_regs.sv
module bpwm_regs
    import bpwm_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    output logic [CNT_W-1:0]  per_o,
    output logic [CNT_W-1:0]  duty_o,
    output logic [CNT_W-1:0]  tmr_o,
    output logic [CNT_W-1:0]  tmr_nxt_o,
    output logic              hit_o,
    output logic              ctrl_wr_o,
    output logic              ctrl_bit_o
);
    localparam int NPAIR = 3;
    localparam logic [BYTE_W-1:0] LO_ADDR [NPAIR] = '{A_PER_LO, A_DUTY_LO, A_TMR_LO};
    localparam logic [BYTE_W-1:0] HI_ADDR [NPAIR] = '{A_PER_HI, A_DUTY_HI, A_TMR_HI};

    assign hit_o      = wr_en && (wr_addr >= A_TMR_HI) && (wr_addr <= A_DUTY_HI);
    assign ctrl_wr_o  = wr_en && (wr_addr == A_CTRL);
    assign ctrl_bit_o = wr_data[0];

    for (genvar g = 0; g < NPAIR; g++) begin : g_pair
        logic [BYTE_W-1:0] stage_q;
        logic [CNT_W-1:0]  live_q;
        logic [CNT_W-1:0]  live_d;

        always_comb begin
            live_d = live_q;
            if (wr_en && (wr_addr == LO_ADDR[g]))
                live_d = {stage_q, wr_data};
        end

        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                stage_q <= '0;
                live_q  <= '0;
            end else begin
                if (wr_en && (wr_addr == HI_ADDR[g]))
                    stage_q <= wr_data;
                live_q <= live_d;
            end
        end
    end

    assign per_o     = g_pair[0].live_q;
    assign duty_o    = g_pair[1].live_q;
    assign tmr_o     = g_pair[2].live_q;
    assign tmr_nxt_o = g_pair[2].live_d;

    // R3: an upper-byte write alone leaves the live period untouched
    a_r3_hi_staged: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_PER_HI) |=> $stable(per_o));

    // R3: the lower-byte write lands in the live pulse width
    a_r3_lo_commit: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_addr == A_DUTY_LO) |=> (duty_o[BYTE_W-1:0] == $past(wr_data)));

    // R10: out-of-range writes leave all live values as they were
    a_r10_out_of_range: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !hit_o) |=> ($stable(per_o) && $stable(duty_o) && $stable(tmr_o)));
endmodule

// File: rtl/bpwm_autooff.sv
module bpwm_autooff
    import bpwm_pkg::*;
#(
    parameter int TICKS_PER_MS = 8000
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             hit_i,
    input  logic             ctrl_wr_i,
    input  logic             ctrl_bit_i,
    input  logic [CNT_W-1:0] tmr_nxt_i,
    output logic             run_o
);
    localparam int PRE_W = (TICKS_PER_MS > 1) ? $clog2(TICKS_PER_MS) : 1;
    localparam logic [PRE_W-1:0] PRE_LAST = PRE_W'(TICKS_PER_MS - 1);

    run_st_e          state_q, state_d, armed;
    logic [PRE_W-1:0] pre_q;
    logic [CNT_W-1:0] left_q;
    logic             ms_tick, expire;

    assign armed   = (tmr_nxt_i == TMR_NEVER) ? ST_FREE : ST_TIMED;
    assign ms_tick = (state_q == ST_TIMED) && !hit_i && (pre_q == PRE_LAST);
    assign expire  = ms_tick && (left_q <= CNT_W'(1));

    // next-state decision
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (ctrl_wr_i && ctrl_bit_i) state_d = armed;        // start
            end
            ST_FREE, ST_TIMED: begin
                if (ctrl_wr_i && !ctrl_bit_i) state_d = ST_IDLE;     // stop
                else if (hit_i)               state_d = armed;       // rearm
                else if (expire)              state_d = ST_IDLE;     // expire
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // countdown and prescaler
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pre_q  <= '0;
            left_q <= '0;
        end else begin
            if (hit_i || state_q != ST_TIMED) pre_q <= '0;
            else if (pre_q == PRE_LAST)       pre_q <= '0;
            else                              pre_q <= pre_q + 1'b1;

            if (hit_i)        left_q <= tmr_nxt_i;
            else if (expire)  left_q <= '0;
            else if (ms_tick) left_q <= left_q - 1'b1;
        end
    end

    // outputs
    always_comb run_o = (state_q != ST_IDLE);

    // R5: a stop write always ends in IDLE
    a_r5_stop: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_wr_i && !ctrl_bit_i) |=> !run_o);

    // R7: FREE is left only through a write
    a_r7_free_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_FREE && !hit_i) |=> (state_q == ST_FREE));

    // R8: with budget left the countdown cannot switch the output off
    a_r8_no_early_off: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_TIMED && left_q > CNT_W'(1) && !hit_i) |=> (state_q == ST_TIMED));

    // R9: every in-range write reloads the countdown
    a_r9_reload: assert property (@(posedge clk) disable iff (!rst_n)
        hit_i |=> (left_q == $past(tmr_nxt_i)));
endmodule

// File: rtl/bpwm_wave.sv
module bpwm_wave
    import bpwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic [CNT_W-1:0] per_i,
    input  logic [CNT_W-1:0] duty_i,
    output logic             pwm_o
);
    logic [CNT_W-1:0] cnt_q;
    logic             wrap;

    assign wrap = (per_i == '0) || (cnt_q >= per_i - CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)            cnt_q <= '0;
        else if (!run_i || wrap) cnt_q <= '0;
        else                   cnt_q <= cnt_q + 1'b1;
    end

    always_comb pwm_o = run_i && (per_i != '0) && (cnt_q < duty_i);

    // R2: the count returns to zero once it reaches the end of the period
    a_r2_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && per_i != '0 && cnt_q >= per_i - CNT_W'(1)) |=> (cnt_q == '0));

    // R5: a fresh start begins a period at count zero
    a_r5_restart: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(run_i) |-> (cnt_q == '0));

    // R4: pulse width at or above a settled period gives a solid high
    a_r4_full: assert property (@(posedge clk) disable iff (!rst_n)
        (run_i && $past(run_i) && $stable(per_i) && per_i != '0 && duty_i >= per_i) |-> pwm_o);

    // R6: a zero period parks the count
    a_r6_zero_period: assert property (@(posedge clk) disable iff (!rst_n)
        (per_i == '0) |=> (cnt_q == '0));
endmodule

// File: rtl/bytereg_pwm.sv
module bytereg_pwm
    import bpwm_pkg::*;
#(
    parameter int TICKS_PER_MS = 8000
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        wr_en,
    input  logic [7:0]  wr_addr,
    input  logic [7:0]  wr_data,
    output logic        pwm_o
);
    logic [CNT_W-1:0] per, duty, tmr, tmr_nxt;
    logic             hit, ctrl_wr, ctrl_bit, run;

    bpwm_regs u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_data    (wr_data),
        .per_o      (per),
        .duty_o     (duty),
        .tmr_o      (tmr),
        .tmr_nxt_o  (tmr_nxt),
        .hit_o      (hit),
        .ctrl_wr_o  (ctrl_wr),
        .ctrl_bit_o (ctrl_bit)
    );

    bpwm_autooff #(.TICKS_PER_MS(TICKS_PER_MS)) u_off (
        .clk        (clk),
        .rst_n      (rst_n),
        .hit_i      (hit),
        .ctrl_wr_i  (ctrl_wr),
        .ctrl_bit_i (ctrl_bit),
        .tmr_nxt_i  (tmr_nxt),
        .run_o      (run)
    );

    bpwm_wave u_wave (
        .clk    (clk),
        .rst_n  (rst_n),
        .run_i  (run),
        .per_i  (per),
        .duty_i (duty),
        .pwm_o  (pwm_o)
    );

    // R1: reset leaves the preload cleared and the output low
    a_r1_reset_low: assert property (@(posedge clk)
        !rst_n |=> (!pwm_o && tmr == '0));
endmodule

// File: tb/sim_bytereg_pwm.sv
module sim_bytereg_pwm;
    localparam int TPM = 6;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       wr_en = 1'b0;
    logic [7:0] wr_addr = 8'h00;
    logic [7:0] wr_data = 8'h00;
    logic       pwm_o;

    always #5 clk = ~clk;

    bytereg_pwm #(.TICKS_PER_MS(TPM)) u0 (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .pwm_o(pwm_o)
    );

    int vectors = 0;
    int errors  = 0;
    bit done    = 0;

    // reference model: index 0 period, 1 pulse width, 2 countdown preload
    localparam logic [7:0] LO_A [3] = '{8'hA4, 8'hA6, 8'hA2};
    localparam logic [7:0] HI_A [3] = '{8'hA5, 8'hA7, 8'hA1};
    logic [15:0] m_live [3];
    logic [7:0]  m_stage [3];
    int          m_st;      // 0 idle, 1 free, 2 timed
    logic [15:0] m_left;
    int          m_pre;
    logic [15:0] m_cnt;

    function automatic bit m_out();
        return (m_st != 0) && (m_live[0] != 16'd0) && (m_cnt < m_live[1]);
    endfunction

    function automatic string m_tag();
        if (m_st == 0)               return "R5";
        if (m_live[0] == 16'd0)      return "R6";
        if (m_live[1] >= m_live[0])  return "R4";
        return "R2";
    endfunction

    task automatic m_reset();
        for (int i = 0; i < 3; i++) begin
            m_live[i]  = '0;
            m_stage[i] = '0;
        end
        m_st = 0; m_left = '0; m_pre = 0; m_cnt = '0;
    endtask

    task automatic m_advance(input bit w, input logic [7:0] a, input logic [7:0] d);
        logic [15:0] nl [3];
        bit hit, tick;
        int nst, arm;
        hit = w && (a >= 8'hA1) && (a <= 8'hA7);
        for (int i = 0; i < 3; i++) begin
            nl[i] = m_live[i];
            if (w && a == LO_A[i]) nl[i] = {m_stage[i], d};
        end
        arm  = (nl[2] == 16'hFFFF) ? 1 : 2;
        tick = (m_st == 2) && !hit && (m_pre == TPM - 1);
        if (w && a == 8'hA3)          nst = d[0] ? arm : 0;
        else if (hit && m_st != 0)    nst = arm;
        else if (tick && m_left <= 1) nst = 0;
        else                          nst = m_st;
        // wave count uses current live values
        if (m_st == 0 || m_live[0] == 0 || m_cnt >= m_live[0] - 16'd1) m_cnt = 0;
        else m_cnt = m_cnt + 16'd1;
        if (hit)       m_left = nl[2];
        else if (tick) m_left = (m_left <= 1) ? 16'd0 : m_left - 16'd1;
        if (hit || m_st != 2)    m_pre = 0;
        else if (m_pre == TPM-1) m_pre = 0;
        else                     m_pre = m_pre + 1;
        for (int i = 0; i < 3; i++) begin
            if (w && a == HI_A[i]) m_stage[i] = d;
            m_live[i] = nl[i];
        end
        m_st = nst;
    endtask

    task automatic check(input bit exp, input string tag);
        vectors++;
        if (pwm_o !== exp) begin
            errors++;
            $display("FAIL %s: pwm_o=%b expected %b at %0t", tag, pwm_o, exp, $time);
        end
    endtask

    task automatic step(input bit w, input logic [7:0] a, input logic [7:0] d,
                        input string tag = "");
        @(negedge clk);
        check(m_out(), (tag == "") ? m_tag() : tag);
        wr_en = w; wr_addr = a; wr_data = d;
        m_advance(w, a, d);
    endtask

    task automatic idle(input int n, input string tag = "");
        for (int i = 0; i < n; i++) step(1'b0, 8'h00, 8'h00, tag);
    endtask

    task automatic wr16(input logic [7:0] lo, input logic [7:0] hi,
                        input logic [15:0] v, input string tag = "");
        step(1'b1, hi, v[15:8], tag);
        step(1'b1, lo, v[7:0], tag);
    endtask

    function automatic logic [7:0] rnd_data(input logic [7:0] a);
        case (a)
            8'hA5, 8'hA7: return ($urandom % 6 == 0) ? 8'($urandom % 3) : 8'h00;
            8'hA4, 8'hA6: return 8'($urandom % 24);
            8'hA1:        return ($urandom % 3 == 0) ? 8'hFF : 8'h00;
            8'hA2:        return ($urandom % 3 == 0) ? 8'hFF : 8'($urandom % 5);
            8'hA3:        return ($urandom % 4 != 0) ? 8'h01 : 8'h00;
            default:      return 8'($urandom);
        endcase
    endfunction

    task automatic finish_run();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            finish_run();
        end
    end

    initial begin
        void'($urandom(32'd20241));
        m_reset();
        // R1: output low during reset
        repeat (3) begin
            @(negedge clk);
            check(1'b0, "R1");
        end
        rst_n = 1'b1;
        m_advance(1'b0, 8'h00, 8'h00);
        idle(4, "R1");

        // free-running: preload all ones, period 10, pulse width 3
        wr16(8'hA2, 8'hA1, 16'hFFFF, "R7");
        wr16(8'hA4, 8'hA5, 16'd10, "R1");
        wr16(8'hA6, 8'hA7, 16'd3, "R1");
        step(1'b1, 8'hA3, 8'h01, "R5");
        @(negedge clk);
        check(1'b1, "R5");          // first cycle after start is high
        wr_en = 1'b0;
        m_advance(1'b0, 8'h00, 8'h00);
        idle(30, "R2");

        // R3: staged upper byte is invisible until the lower byte
        step(1'b1, 8'hA5, 8'h01, "R3");
        idle(20, "R3");
        step(1'b1, 8'hA4, 8'h00, "R3");
        idle(30, "R3");
        wr16(8'hA4, 8'hA5, 16'd10, "R3");
        idle(12, "R3");

        // R4: pulse width above period
        step(1'b1, 8'hA6, 8'd20, "R4");
        idle(25, "R4");
        step(1'b1, 8'hA6, 8'd10, "R4");
        idle(15, "R4");
        step(1'b1, 8'hA6, 8'd3, "R2");

        // R6: zero period
        wr16(8'hA4, 8'hA5, 16'd0, "R6");
        idle(15, "R6");
        wr16(8'hA4, 8'hA5, 16'd10, "R6");
        idle(10, "R2");

        // R10: out-of-range writes
        step(1'b1, 8'hA0, 8'h55, "R10");
        step(1'b1, 8'hA8, 8'h00, "R10");
        step(1'b1, 8'h00, 8'hFF, "R10");
        step(1'b1, 8'hFF, 8'h00, "R10");
        idle(20, "R10");

        // R5: stop and restart
        step(1'b1, 8'hA3, 8'h00, "R5");
        idle(10, "R5");
        step(1'b1, 8'hA3, 8'h01, "R5");
        idle(12, "R5");

        // R7: no self turn-off with all-ones preload
        idle(100, "R7");

        // R8: countdown of 3 ms ticks
        wr16(8'hA4, 8'hA5, 16'd4, "R8");
        wr16(8'hA6, 8'hA7, 16'd2, "R8");
        wr16(8'hA2, 8'hA1, 16'd3, "R8");
        idle(3 * TPM + 10, "R8");
        // R8: preload zero expires at first tick
        wr16(8'hA2, 8'hA1, 16'd0, "R8");
        step(1'b1, 8'hA3, 8'h01, "R8");
        idle(TPM + 6, "R8");

        // R9: writes closer than the expiry keep it alive
        wr16(8'hA2, 8'hA1, 16'd2, "R9");
        step(1'b1, 8'hA3, 8'h01, "R9");
        for (int k = 0; k < 6; k++) begin
            idle(2 * TPM - 3, "R9");
            step(1'b1, 8'hA6, 8'd2, "R9");
        end
        idle(3 * TPM, "R9");

        // constrained random
        for (int n = 0; n < 20000; n++) begin
            if ($urandom % 12 == 0) begin
                logic [7:0] a;
                a = 8'hA0 + 8'($urandom % 9);
                step(1'b1, a, rnd_data(a));
            end else begin
                step(1'b0, 8'h00, 8'h00);
            end
        end

        done = 1'b1;
        finish_run();
    end
endmodule